// File: doc/BRIEF.md
# Two-Stage Latched Code Register for an 8-bit DAC

This block holds the digital code that drives an 8-bit multiplying converter. It has two storage stages in series. The first stage, the holding stage, takes a byte from the data inputs when a qualified write is present. The second stage, the output stage, copies the holding stage onto the converter code when a transfer is present.

Each control input works on its level, so a stage stays transparent for as long as its controls enable it. The model samples every control and data input on the rising clock edge. The block drives both the converter code and its bitwise complement.

The control inputs can be tied to fixed levels to pick the mode of operation:
- Double-buffered: one write loads the holding stage. A separate transfer, which may be shared by many converters, moves the byte to the output.
- Single-buffered: the transfer is held active, and one write strobe updates the output.
- Flow-through: every control is held active, and the code follows the data inputs.

Top module: `dac_code_reg`

## Requirements
- R1: While `rst` is high at a rising edge, both stages clear, so `code` reads 0 and `code_n` reads 255 from the following cycle on.
- R2: When `sel_n`=0, `wr_a_n`=0 and `load_en`=1 are all true at an edge, the holding stage takes `din` at that edge.
- R3: When `sel_n` or `wr_a_n` is high at an edge, the holding stage keeps its value.
- R4: When `load_en` is 0 at an edge, the holding stage keeps its value whatever `sel_n` and `wr_a_n` are.
- R5: When `wr_b_n`=0 and `xfer_n`=0 at an edge, `code` takes the holding-stage value that was present before that edge.
- R6: When `wr_b_n` or `xfer_n` is high at an edge, `code` does not change.
- R7: When every control is held active (all active-low controls at 0 and `load_en` at 1), `code` equals the value of `din` from two edges earlier.
- R8: When `wr_b_n`=0, `xfer_n`=0, `sel_n`=0 and `load_en`=1 are held, a low pulse on `wr_a_n` alone is enough to update `code`.
- R9: `code_n` always equals 255 minus `code`.
- R10: Bit order is kept: `din[0]` reaches `code[0]` as the LSB and `din[7]` reaches `code[7]` as the MSB. An input of all ones gives `code`=255, and all zeros gives `code`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Data byte; bit 0 is the LSB |
| sel_n | input | 1 | Device select, active low |
| wr_a_n | input | 1 | Holding-stage write strobe, active low |
| load_en | input | 1 | Holding-stage enable, active high |
| wr_b_n | input | 1 | Output-stage write strobe, active low |
| xfer_n | input | 1 | Transfer strobe, active low |
| code | output | 8 | Converter code |
| code_n | output | 8 | Complement of the converter code |

## Verification
The assertions take all inputs to be known (0 or 1) at every sampling edge. They also treat reset as the only thing that can change a stage outside its enable conditions. The stimulus keeps to this in three ways:
- it drives every input to a defined level from time zero;
- it changes inputs only on the falling edge;
- it holds reset for the first cycles.

The reference model in the bench follows the same edge-sampled reading of the level-actuated controls.

// File: rtl/dac_code_reg.sv
module dac_code_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         sel_n,
  input  logic         wr_a_n,
  input  logic         load_en,
  input  logic         wr_b_n,
  input  logic         xfer_n,
  output logic [W-1:0] code,
  output logic [W-1:0] code_n
);

  logic [W-1:0] hold_q;
  logic [W-1:0] out_q;
  logic         ld_ok;
  logic         xf_ok;

  assign ld_ok = ~sel_n & ~wr_a_n & load_en;
  assign xf_ok = ~wr_b_n & ~xfer_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      out_q  <= '0;
    end else begin
      if (ld_ok) hold_q <= din;
      if (xf_ok) out_q  <= hold_q;
    end
  end

  assign code   = out_q;
  assign code_n = ~out_q;

  p_load_takes_din_r2: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !wr_a_n && load_en) |=> (hold_q == $past(din)));

  p_hold_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    (sel_n || wr_a_n) |=> $stable(hold_q));

  p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(hold_q));

  p_xfer_copies_r5: assert property (@(posedge clk) disable iff (rst)
    (!wr_b_n && !xfer_n) |=> (code == $past(hold_q)));

  p_code_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_b_n || xfer_n) |=> $stable(code));

endmodule

// File: tb/sim_dac_code_reg.sv
module sim_dac_code_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = 8'h00;
  logic       sel_n = 1'b1, wr_a_n = 1'b1, load_en = 1'b0, wr_b_n = 1'b1, xfer_n = 1'b1;
  logic [7:0] code, code_n;

  typedef struct {
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t      sb[$];
  int         n_run = 0;
  int         n_fail = 0;
  logic [7:0] m_hold = 8'h00;
  logic [7:0] m_out = 8'h00;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  dac_code_reg u0 (
    .clk(clk), .rst(rst), .din(din), .sel_n(sel_n), .wr_a_n(wr_a_n),
    .load_en(load_en), .wr_b_n(wr_b_n), .xfer_n(xfer_n),
    .code(code), .code_n(code_n)
  );

  task automatic step(input logic r, input logic [7:0] d, input logic cs, input logic w1,
                      input logic ile, input logic w2, input logic xf, input string req);
    item_t it;
    logic [7:0] nh, no;
    @(negedge clk);
    rst = r; din = d; sel_n = cs; wr_a_n = w1; load_en = ile; wr_b_n = w2; xfer_n = xf;
    if (r) begin
      nh = 8'h00; no = 8'h00;
    end else begin
      nh = (!cs && !w1 && ile) ? d : m_hold;
      no = (!w2 && !xf) ? m_hold : m_out;
    end
    m_hold = nh; m_out = no;
    it.exp = no; it.req = req;
    sb.push_back(it);
  endtask

  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_run++;
      if (code !== it.exp) begin
        n_fail++;
        $display("FAIL %s code=%h expected %h", it.req, code, it.exp);
      end
      n_run++;
      if (code_n !== (8'd255 - it.exp)) begin
        n_fail++;
        $display("FAIL R9 code_n=%h expected %h", code_n, 8'd255 - it.exp);
      end
    end
  end

  initial begin
    step(1, 8'h5A, 0, 0, 1, 0, 0, "R1");
    step(1, 8'h5A, 0, 0, 1, 0, 0, "R1");
    step(0, 8'hA5, 0, 0, 1, 1, 1, "R2 R6");
    step(0, 8'h11, 1, 1, 1, 1, 0, "R6");
    step(0, 8'h22, 1, 1, 1, 0, 0, "R5");
    step(0, 8'h3C, 1, 0, 1, 0, 0, "R3");
    step(0, 8'h3C, 0, 1, 1, 0, 0, "R3");
    step(0, 8'hFF, 0, 0, 0, 0, 0, "R4");
    step(0, 8'h77, 0, 0, 0, 0, 0, "R4");
    step(0, 8'h66, 0, 0, 1, 0, 1, "R2 R6");
    step(0, 8'h00, 1, 1, 1, 0, 0, "R5");
    for (int i = 0; i < 8; i++)
      step(0, 8'(i * 37 + 3), 0, 0, 1, 0, 0, "R7");
    step(0, 8'h01, 0, 0, 1, 0, 0, "R10");
    step(0, 8'hFF, 0, 0, 1, 0, 0, "R10");
    step(0, 8'h80, 0, 0, 1, 0, 0, "R10");
    step(0, 8'h00, 0, 0, 1, 0, 0, "R10");
    step(0, 8'h00, 0, 0, 1, 0, 0, "R10");
    step(0, 8'h00, 0, 1, 1, 0, 0, "R8");
    step(0, 8'hC3, 0, 1, 1, 0, 0, "R8");
    step(0, 8'hC3, 0, 0, 1, 0, 0, "R8");
    step(0, 8'h18, 0, 1, 1, 0, 0, "R8");
    step(0, 8'h18, 0, 1, 1, 0, 0, "R8");
    step(0, 8'h18, 0, 1, 1, 0, 0, "R8");
    step(1, 8'h18, 0, 1, 1, 0, 0, "R1");
    step(0, 8'h18, 1, 1, 1, 1, 1, "R1");
    wait (sb.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule